// File: doc/BRIEF.md
# Interference Covariance Trace Unit

This unit produces the scalar covariance term that a past or a future block contributes to the equalizer's interference estimate. After a start pulse it takes in one block of K channel samples, arriving one at a time. Each sample is a pair: a value for the convolution (the squared-magnitude channel response) and a diagonal value (the matching conjugate channel value). The samples are convolved cyclically with a fixed kernel of 2N taps. Each convolution output is multiplied by the diagonal value of the same position. The K products are summed, and the sum is divided by K with an arithmetic right shift of log2(K) bits.

The kernel is held in a small weight file that is written through a load port while the unit is idle. It keeps its contents from one block to the next. A rotating sample store moves the inputs past 2N fixed taps, and the tap products are summed into one output per cycle. A single serial multiplier and a wide accumulator then form the trace. The shifted result saturates to the output width and is marked by a one-cycle done strobe.

Top module: `covtrace_unit`

## Requirements
- R1: Out of reset, busy_o and done_o are low and result_o is zero.
- R2: A start pulse while idle raises busy_o on the next cycle. The next K cycles with smp_valid_i high each capture one sample pair, in order 0..K-1. Cycles with smp_valid_i low capture nothing.
- R3: Convolution output k is y[k] = sum over j=0..2N-1 of c[j]·x[(k+j−N) mod K]. Here c[j] is the weight written with kw_idx_i = j. Equivalently, y[k] = sum over i of p[(i−k) mod K]·x[i], where p[(j−N) mod K] = c[j] and all other entries of p are zero.
- R4: The result is floor((sum over k of y[k]·d[k]) / K), where d[k] is the diagonal value of sample k. This is an arithmetic right shift, so it rounds toward minus infinity.
- R5: A result outside the signed OUT_W range is clamped to +2^(OUT_W−1)−1 or −2^(OUT_W−1).
- R6: done_o is high for exactly one cycle. It rises after the (K+1)th rising edge following the edge that captures the last sample. busy_o is low in that cycle.
- R7: result_o changes only in the cycle in which done_o is high and holds its value in between.
- R8: While busy_o is high, start pulses and kernel writes are ignored. The accumulator clears on an accepted start, so each block's result depends on that block alone.
- R9: Kernel weights persist across blocks until they are rewritten.
- R10: All inputs and weights are 9-bit signed two's complement by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a block when idle |
| smp_valid_i | input | 1 | Qualifies a sample pair |
| smp_conv_i | input | DW | Convolution input value (signed) |
| smp_diag_i | input | DW | Diagonal channel value (signed) |
| kw_we_i | input | 1 | Kernel weight write enable |
| kw_idx_i | input | $clog2(2N) | Kernel tap index j |
| kw_data_i | input | DW | Kernel weight value (signed) |
| busy_o | output | 1 | Block in progress |
| done_o | output | 1 | One-cycle result strobe |
| result_o | output | OUT_W | Saturated, normalised trace (signed) |

## Verification
The hardest cases to reach from the ports are writes and starts that arrive while a block is running. Those must leave the result of that block untouched. The bench covers them by issuing a kernel write and a start pulse in the middle of sample capture and again during the convolution phase. It then compares the result with a value computed from the original weights, and runs a second block to show that the weights were not changed. Floor rounding is reached with a single product of −1, which a truncating divider would return as zero. Both saturation limits are reached with full-scale samples and weights.

// File: rtl/covtrace_pkg.sv
package covtrace_pkg;
  typedef enum logic [1:0] {
    CT_IDLE  = 2'd0,
    CT_LOAD  = 2'd1,
    CT_RUN   = 2'd2,
    CT_DRAIN = 2'd3
  } ct_state_e;
endpackage

// File: rtl/covtrace_kernel.sv
module covtrace_kernel #(
  parameter int TAPS = 32,
  parameter int DW   = 9,
  localparam int IW  = $clog2(TAPS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we_i,
  input  logic [IW-1:0]        idx_i,
  input  logic signed [DW-1:0] data_i,
  input  logic                 lock_i,
  output logic                 commit_o,
  output logic signed [DW-1:0] w_o [TAPS]
);
  assign commit_o = we_i & ~lock_i;

  for (genvar j = 0; j < TAPS; j++) begin : g_w
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) w_o[j] <= '0;
      else if (commit_o && (idx_i == IW'(j))) w_o[j] <= data_i;
    end
  end
endmodule

// File: rtl/covtrace_window.sv
module covtrace_window #(
  parameter int K      = 128,
  parameter int HALF   = 16,
  parameter int DW     = 9,
  localparam int TAPS  = 2 * HALF,
  localparam int PW    = 2 * DW,
  localparam int CONV_W = PW + $clog2(TAPS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ld_en_i,
  input  logic                     rot_en_i,
  input  logic signed [DW-1:0]     x_i,
  input  logic signed [DW-1:0]     d_i,
  input  logic signed [DW-1:0]     w_i [TAPS],
  output logic signed [CONV_W-1:0] conv_o,
  output logic signed [DW-1:0]     diag_o
);
  logic signed [DW-1:0] xr [K];
  logic signed [DW-1:0] dr [K];
  logic signed [PW-1:0] prod [TAPS];
  logic                 step;

  assign step = ld_en_i | rot_en_i;

  // Sample store: loads shift in at the top, rotation feeds entry 0 back to the top.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int m = 0; m < K; m++) begin
        xr[m] <= '0;
        dr[m] <= '0;
      end
    end else if (step) begin
      for (int m = 0; m < K - 1; m++) begin
        xr[m] <= xr[m+1];
        dr[m] <= dr[m+1];
      end
      xr[K-1] <= ld_en_i ? x_i : xr[0];
      dr[K-1] <= ld_en_i ? d_i : dr[0];
    end
  end

  // Fixed taps: tap j sees x[(k + j - HALF) mod K] at rotation step k.
  for (genvar j = 0; j < TAPS; j++) begin : g_tap
    localparam int POS = (j - HALF + K) % K;
    logic signed [PW-1:0] xe, we;
    assign xe = {{DW{xr[POS][DW-1]}}, xr[POS]};
    assign we = {{DW{w_i[j][DW-1]}}, w_i[j]};
    assign prod[j] = xe * we;
  end

  always_comb begin
    conv_o = '0;
    for (int j = 0; j < TAPS; j++)
      conv_o = conv_o + {{(CONV_W-PW){prod[j][PW-1]}}, prod[j]};
  end

  assign diag_o = dr[0];
endmodule

// File: rtl/covtrace_ctrl.sv
module covtrace_ctrl
  import covtrace_pkg::*;
#(
  parameter int K = 128,
  localparam int CW = $clog2(K) + 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic valid_i,
  output logic busy_o,
  output logic clr_o,
  output logic ld_en_o,
  output logic rot_en_o,
  output logic last_o
);
  ct_state_e       state_q, state_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            at_end;

  assign at_end   = (cnt_q == CW'(K - 1));
  assign busy_o   = (state_q != CT_IDLE);
  assign clr_o    = (state_q == CT_IDLE) && start_i;
  assign ld_en_o  = (state_q == CT_LOAD) && valid_i;
  assign rot_en_o = (state_q == CT_RUN);
  assign last_o   = rot_en_o && at_end;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      CT_IDLE: if (start_i) begin
        state_d = CT_LOAD;
        cnt_d   = '0;
      end
      CT_LOAD: if (ld_en_o) begin
        cnt_d = at_end ? '0 : cnt_q + 1'b1;
        if (at_end) state_d = CT_RUN;
      end
      CT_RUN: begin
        cnt_d = at_end ? '0 : cnt_q + 1'b1;
        if (at_end) state_d = CT_DRAIN;
      end
      CT_DRAIN: state_d = CT_IDLE;
      default:  state_d = CT_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CT_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/covtrace_unit.sv
module covtrace_unit #(
  parameter int K     = 128,
  parameter int HALF  = 16,
  parameter int DW    = 9,
  parameter int OUT_W = 16,
  localparam int TAPS   = 2 * HALF,
  localparam int IW     = $clog2(TAPS),
  localparam int SHIFT  = $clog2(K),
  localparam int CONV_W = 2 * DW + $clog2(TAPS),
  localparam int MUL_W  = CONV_W + DW,
  localparam int ACC_W  = MUL_W + SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             smp_valid_i,
  input  logic [DW-1:0]    smp_conv_i,
  input  logic [DW-1:0]    smp_diag_i,
  input  logic             kw_we_i,
  input  logic [IW-1:0]    kw_idx_i,
  input  logic [DW-1:0]    kw_data_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [OUT_W-1:0] result_o
);
  localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'((64'sd1 <<< (OUT_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] SAT_LO = -SAT_HI - 1;

  function automatic logic signed [MUL_W-1:0] mul_fn(
    input logic signed [CONV_W-1:0] a, input logic signed [DW-1:0] b);
    logic signed [MUL_W-1:0] ae, be;
    ae = {{(MUL_W-CONV_W){a[CONV_W-1]}}, a};
    be = {{(MUL_W-DW){b[DW-1]}}, b};
    return ae * be;
  endfunction

  function automatic logic signed [OUT_W-1:0] norm_sat_fn(input logic signed [ACC_W-1:0] v);
    logic signed [ACC_W-1:0] s;
    s = v >>> SHIFT;
    if (s > SAT_HI)      return SAT_HI[OUT_W-1:0];
    else if (s < SAT_LO) return SAT_LO[OUT_W-1:0];
    else                 return s[OUT_W-1:0];
  endfunction

  logic                     clr, ld_en, rot_en, last, kw_commit;
  logic signed [DW-1:0]     weights [TAPS];
  logic signed [CONV_W-1:0] conv_w;
  logic signed [DW-1:0]     diag_w;
  logic signed [CONV_W-1:0] s1_conv;
  logic signed [DW-1:0]     s1_diag;
  logic                     s1_v, s1_last;
  logic signed [MUL_W-1:0]  prod_w;
  logic signed [ACC_W-1:0]  acc_q, acc_next;
  logic                     fin_w;

  covtrace_ctrl #(.K(K)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .valid_i(smp_valid_i),
    .busy_o(busy_o), .clr_o(clr), .ld_en_o(ld_en), .rot_en_o(rot_en), .last_o(last)
  );

  covtrace_kernel #(.TAPS(TAPS), .DW(DW)) u_kernel (
    .clk(clk), .rst_n(rst_n), .we_i(kw_we_i), .idx_i(kw_idx_i),
    .data_i(kw_data_i), .lock_i(busy_o), .commit_o(kw_commit), .w_o(weights)
  );

  covtrace_window #(.K(K), .HALF(HALF), .DW(DW)) u_window (
    .clk(clk), .rst_n(rst_n), .ld_en_i(ld_en), .rot_en_i(rot_en),
    .x_i(smp_conv_i), .d_i(smp_diag_i), .w_i(weights),
    .conv_o(conv_w), .diag_o(diag_w)
  );

  // Stage 1: register one convolution output and its diagonal partner.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_conv <= '0;
      s1_diag <= '0;
      s1_v    <= 1'b0;
      s1_last <= 1'b0;
    end else begin
      s1_v    <= rot_en;
      s1_last <= last;
      if (rot_en) begin
        s1_conv <= conv_w;
        s1_diag <= diag_w;
      end
    end
  end

  // Stage 2: shared multiplier into the trace accumulator.
  assign prod_w   = mul_fn(s1_conv, s1_diag);
  assign acc_next = acc_q + {{(ACC_W-MUL_W){prod_w[MUL_W-1]}}, prod_w};
  assign fin_w    = s1_v & s1_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q    <= '0;
      done_o   <= 1'b0;
      result_o <= '0;
    end else begin
      done_o <= fin_w;
      if (clr)       acc_q <= '0;
      else if (s1_v) acc_q <= acc_next;
      if (fin_w) result_o <= norm_sat_fn(acc_next);
    end
  end
endmodule

// File: rtl/covtrace_chk.sv
module covtrace_chk #(
  parameter int K     = 128,
  parameter int ACC_W = 39,
  parameter int OUT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [OUT_W-1:0] result_o,
  input logic             clr,
  input logic             rot_en,
  input logic             kw_commit,
  input logic [ACC_W-1:0] acc_q
);
  localparam int CW = $clog2(K) + 2;
  logic [CW-1:0] rot_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rot_cnt <= '0;
    else if (clr)    rot_cnt <= '0;
    else if (rot_en) rot_cnt <= rot_cnt + 1'b1;
  end

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o); // R2
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o); // R6
  AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (rot_cnt == CW'(K))); // R3
  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(result_o)); // R7
  AST_ACC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (acc_q == '0)); // R8
  AST_KW_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    kw_commit |-> !busy_o); // R8
endmodule

bind covtrace_unit covtrace_chk #(.K(K), .ACC_W(ACC_W), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
  .result_o(result_o), .clr(clr), .rot_en(rot_en), .kw_commit(kw_commit), .acc_q(acc_q)
);

// File: tb/covtrace_unit_tb.sv
module covtrace_unit_tb;
  localparam int K = 128, HALF = 16, DW = 9, OUT_W = 16;
  localparam int TAPS = 2 * HALF, IW = $clog2(TAPS), SHIFT = $clog2(K);

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 0, smp_valid_i = 0, kw_we_i = 0;
  logic [DW-1:0] smp_conv_i = '0, smp_diag_i = '0, kw_data_i = '0;
  logic [IW-1:0] kw_idx_i = '0;
  logic busy_o, done_o;
  logic [OUT_W-1:0] result_o;

  int n_tests = 0, n_fail = 0;
  int cw [TAPS];
  int bx [K];
  int bd [K];
  longint got_res;
  int got_lat;
  bit got_done;

  always #4 clk = ~clk;

  covtrace_unit #(.K(K), .HALF(HALF), .DW(DW), .OUT_W(OUT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .smp_valid_i(smp_valid_i),
    .smp_conv_i(smp_conv_i), .smp_diag_i(smp_diag_i), .kw_we_i(kw_we_i),
    .kw_idx_i(kw_idx_i), .kw_data_i(kw_data_i), .busy_o(busy_o),
    .done_o(done_o), .result_o(result_o)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Model written in the p[(i-k) mod K] form of R3, then R4 and R5.
  function automatic longint model();
    longint acc = 0, y, r, hi, lo;
    int off, coef;
    for (int k = 0; k < K; k++) begin
      y = 0;
      for (int i = 0; i < K; i++) begin
        off = (i - k + K) % K;
        if (off < HALF) coef = cw[off + HALF];
        else if (off >= K - HALF) coef = cw[off - (K - HALF)];
        else coef = 0;
        y += longint'(coef) * bx[i];
      end
      acc += y * bd[k];
    end
    r  = acc >>> SHIFT;
    hi = (64'sd1 <<< (OUT_W - 1)) - 1;
    lo = -hi - 1;
    if (r > hi) r = hi;
    if (r < lo) r = lo;
    return r;
  endfunction

  task automatic write_w(input int j, input int v);
    @(negedge clk);
    kw_we_i = 1; kw_idx_i = IW'(j); kw_data_i = DW'(v);
    @(negedge clk);
    kw_we_i = 0;
  endtask

  task automatic load_kernel();
    for (int j = 0; j < TAPS; j++) write_w(j, cw[j]);
  endtask

  // Runs one block; mode 1 inserts idle gaps, mode 2 pokes start/kernel while busy.
  task automatic run_block(input int mode);
    int n;
    got_done = 0;
    @(negedge clk);
    start_i = 1;
    @(negedge clk);
    start_i = 0;
    for (int i = 0; i < K; i++) begin
      if (mode == 1 && (i % 3) == 0) begin
        smp_valid_i = 0; smp_conv_i = DW'(77); smp_diag_i = DW'(-5);
        @(negedge clk);
      end
      smp_valid_i = 1; smp_conv_i = DW'(bx[i]); smp_diag_i = DW'(bd[i]);
      if (mode == 2 && i == K / 2) begin
        start_i = 1; kw_we_i = 1; kw_idx_i = IW'(HALF); kw_data_i = DW'(cw[HALF] + 9);
      end
      if (i < K - 1) begin
        @(negedge clk);
        start_i = 0; kw_we_i = 0;
      end
    end
    n = 0;
    while (n < 4 * K) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      smp_valid_i = 0; start_i = 0; kw_we_i = 0;
      if (mode == 2 && n == K / 2) begin
        start_i = 1; kw_we_i = 1; kw_idx_i = IW'(0); kw_data_i = DW'(cw[0] - 3);
      end
      if (done_o) begin
        got_done = 1;
        break;
      end
    end
    start_i = 0; kw_we_i = 0;
    got_lat = n;
    got_res = longint'($signed(result_o));
    chk("R6 done seen", got_done, 1);
    chk("R6 busy low at done", busy_o, 0);
    @(negedge clk);
    chk("R6 done single cycle", done_o, 0);
  endtask

  task automatic t_reset();
    chk("R1 busy after reset", busy_o, 0);
    chk("R1 done after reset", done_o, 0);
    chk("R1 result after reset", result_o, 0);
  endtask

  task automatic t_identity();
    for (int j = 0; j < TAPS; j++) cw[j] = 0;
    cw[HALF] = 1;
    for (int i = 0; i < K; i++) begin
      bx[i] = (i * 7) % 200 - 100;
      bd[i] = (i * 13) % 150 - 60;
    end
    load_kernel();
    run_block(0);
    chk("R3 identity kernel trace", got_res, model());
    chk("R6 latency", got_lat, K + 2);
  endtask

  task automatic t_shifted_taps();
    for (int j = 0; j < TAPS; j++) cw[j] = 0;
    cw[0] = 3; cw[TAPS-1] = -2;
    for (int i = 0; i < K; i++) begin
      bx[i] = (i < 4) ? 100 + i : 0;
      bd[i] = (i >= K - 20 || i < 20) ? 50 - i % 7 : 0;
    end
    load_kernel();
    run_block(0);
    chk("R3 wrap-around taps", got_res, model());
  endtask

  task automatic t_random();
    for (int j = 0; j < TAPS; j++) cw[j] = int'($urandom_range(0, 511)) - 256;
    for (int i = 0; i < K; i++) begin
      bx[i] = int'($urandom_range(0, 511)) - 256;
      bd[i] = int'($urandom_range(0, 511)) - 256;
    end
    load_kernel();
    run_block(0);
    chk("R3 R10 random signed block", got_res, model());
  endtask

  task automatic t_floor();
    for (int j = 0; j < TAPS; j++) cw[j] = 0;
    cw[HALF] = 1;
    for (int i = 0; i < K; i++) begin bx[i] = 0; bd[i] = 0; end
    bx[5] = 1; bd[5] = -1;
    load_kernel();
    run_block(0);
    chk("R4 floor of -1/K", got_res, -1);
    bx[5] = 200; bd[5] = 1;
    run_block(0);
    chk("R4 positive shift", got_res, 1);
  endtask

  task automatic t_saturate();
    for (int j = 0; j < TAPS; j++) cw[j] = 255;
    for (int i = 0; i < K; i++) begin bx[i] = 255; bd[i] = 255; end
    load_kernel();
    run_block(0);
    chk("R5 clamp high", got_res, 32767);
    for (int i = 0; i < K; i++) bd[i] = -256;
    run_block(0);
    chk("R5 clamp low", got_res, -32768);
  endtask

  task automatic t_gaps();
    for (int j = 0; j < TAPS; j++) cw[j] = (j % 5) - 2;
    for (int i = 0; i < K; i++) begin
      bx[i] = (i * 29) % 300 - 150;
      bd[i] = (i * 11) % 90 - 45;
    end
    load_kernel();
    run_block(1);
    chk("R2 gaps in valid ignored", got_res, model());
    chk("R6 latency with gaps", got_lat, K + 2);
  endtask

  task automatic t_busy_ignore();
    longint first;
    for (int j = 0; j < TAPS; j++) cw[j] = 20 - j;
    for (int i = 0; i < K; i++) begin
      bx[i] = (i * 37) % 256 - 128;
      bd[i] = (i * 5) % 64 - 32;
    end
    load_kernel();
    run_block(2);
    first = got_res;
    chk("R8 busy start and writes ignored", first, model());
    run_block(0);
    chk("R9 R8 kernel kept, acc cleared", got_res, first);
  endtask

  task automatic t_hold();
    longint held = longint'($signed(result_o));
    for (int c = 0; c < 10; c++) @(negedge clk);
    chk("R7 result holds", longint'($signed(result_o)), held);
    chk("R7 no spurious done", done_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_identity();
    t_shifted_taps();
    t_random();
    t_floor();
    t_saturate();
    t_gaps();
    t_busy_ignore();
    t_hold();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule